// File: doc/BRIEF.md
# Display Register Window Decoder

This block sits behind a 4 KiB memory-mapped aperture of a display controller. It accepts one request at a time on a simple bus: address, write flag, size code and write data. Each request is routed to one of three sub-windows. The first sub-window reaches the 8-bit legacy display port space. The second is an indexed file of 16-bit extension registers. The third holds a few 32-bit feature registers, one of which selects the byte order of the framebuffer.

Wide accesses to the narrow backends become ordered sequences of single backend strobes, one per clock. While such a sequence is running, `busy_o` is high and new requests are not taken. Each request ends with one cycle of `resp_valid_o`, which carries the read data (zero for writes). The feature sub-window exists only while `feat_en_i` is high, and the reported revision follows that input.

Top module: `disp_mmio_window`

## Requirements
- R1: After reset `busy_o`, `resp_valid_o`, all backend strobes and `big_endian_o` are 0.
- R2: A byte access (size code 0) at offset N of 0x400..0x41F makes one legacy strobe at port 0x3C0+N. A read returns that byte in bits 7:0 with the upper bits zero.
- R3: A 16-bit write (size code 1) to the legacy window makes two byte writes on consecutive cycles. The low data byte goes to port 0x3C0+N first, then the high byte goes to port 0x3C1+N.
- R4: A 16-bit legacy read reads ports 0x3C0+N and 0x3C1+N in that order. The first byte is returned in bits 7:0 and the second in bits 15:8.
- R5: A legacy access with size code 2 or 3 makes four byte strobes at ascending ports (low half first). Byte k of the data maps to bits 8k+7:8k.
- R6: An access at offset M of 0x500..0x515 loads index M>>1 in one cycle, then in the next cycle makes a 16-bit data write (data bits 15:0) or data read. Read data is returned zero-extended.
- R7: With the feature sub-window present, a 32-bit read (size code 2) of 0x600 returns 8.
- R8: A 32-bit read of 0x604 returns 0xBEBEBEBE while big-endian mode is set and 0x1E1E1E1E while it is clear.
- R9: A 32-bit write of exactly 0xBEBEBEBE to 0x604 sets big-endian mode. A write of exactly 0x1E1E1E1E clears it. Any other value leaves the mode unchanged.
- R10: Accesses to 0x600..0x607 with a size code other than 2 read 0 and change nothing. A 32-bit read of an undefined feature offset returns 0.
- R11: While `feat_en_i` is 0, 0x600..0x607 is unmapped and `revision_o` is 1. While it is 1, `revision_o` is 2.
- R12: An access outside all sub-windows makes no backend strobe. Its response comes in the cycle after acceptance, with read data 0.
- R13: A request is accepted only while `busy_o` is low, and requests made while busy are ignored. The response comes in the cycle after the last backend strobe, which gives latency n+1 for n strobes. At most one backend strobe is active per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feat_en_i | input | 1 | Enables the feature sub-window |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset inside the aperture |
| req_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 treated as word |
| req_wdata_i | input | 32 | Write data, little-endian |
| busy_o | output | 1 | A backend sequence is running |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | 32 | Read data, valid with resp_valid_o |
| lp_valid_o | output | 1 | Legacy port strobe |
| lp_write_o | output | 1 | Legacy strobe is a write |
| lp_port_o | output | 10 | Legacy port number |
| lp_wdata_o | output | 8 | Legacy write byte |
| lp_rdata_i | input | 8 | Legacy read byte, valid in the strobe cycle |
| ext_idx_we_o | output | 1 | Extension index load |
| ext_idx_o | output | 4 | Extension register index |
| ext_data_we_o | output | 1 | Extension data write |
| ext_data_re_o | output | 1 | Extension data read |
| ext_wdata_o | output | 16 | Extension write data |
| ext_rdata_i | input | 16 | Extension read data, valid in the data-read cycle |
| big_endian_o | output | 1 | Framebuffer byte-order mode |
| revision_o | output | 8 | Reported device revision |

## Verification
The assertions assume that each backend completes a strobe in the cycle it is issued and that read data is settled in that same cycle. They also assume that the requester keeps `req_valid_i` at a stable level between clock edges. The bench's stub backends answer combinationally: the legacy byte is computed from the port number, and the extension data comes from a register file that the strobes load. A requester that behaves in order waits for each response before it starts the next request. The one exception is a single deliberate overlap, which checks that a request made while busy is dropped.

// File: rtl/disp_mmio_pkg.sv
package disp_mmio_pkg;
  typedef enum logic [1:0] {WIN_NONE, WIN_LEG, WIN_EXT, WIN_FEAT} win_e;
  localparam logic [31:0] MAGIC_BE = 32'hBEBE_BEBE;
  localparam logic [31:0] MAGIC_LE = 32'h1E1E_1E1E;
endpackage

// File: rtl/disp_win_decode.sv
module disp_win_decode
  import disp_mmio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 5,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_SPAN  = 'h16,
  parameter int FEAT_BASE = 'h600,
  parameter int FEAT_SPAN = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              feat_en_i,
  output win_e              win_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [ADDR_W-1:0] LB = ADDR_W'(LEG_BASE);
  localparam logic [ADDR_W-1:0] EB = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] FB = ADDR_W'(FEAT_BASE);

  always_comb begin
    win_o = WIN_NONE;
    off_o = '0;
    if (addr_i >= LB && addr_i < LB + ADDR_W'(LEG_SPAN)) begin
      win_o = WIN_LEG;
      off_o = OFF_W'(addr_i - LB);
    end else if (addr_i >= EB && addr_i < EB + ADDR_W'(EXT_SPAN)) begin
      win_o = WIN_EXT;
      off_o = OFF_W'(addr_i - EB);
    end else if (feat_en_i && addr_i >= FB && addr_i < FB + ADDR_W'(FEAT_SPAN)) begin
      win_o = WIN_FEAT;
      off_o = OFF_W'(addr_i - FB);
    end
  end
endmodule

// File: rtl/disp_feat_regs.sv
module disp_feat_regs
  import disp_mmio_pkg::*;
#(
  parameter int FEAT_SPAN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        write_i,
  input  logic [2:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic        big_endian_o,
  output logic [31:0] rdata_o
);
  logic be_q;
  logic wr_en;

  assign wr_en = sel_i && write_i && off_i == 3'd4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) be_q <= 1'b0;
    else if (wr_en) begin
      if (wdata_i == MAGIC_BE)      be_q <= 1'b1;
      else if (wdata_i == MAGIC_LE) be_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off_i)
      3'd0:    rdata_o = 32'(FEAT_SPAN);
      3'd4:    rdata_o = be_q ? MAGIC_BE : MAGIC_LE;
      default: rdata_o = '0;
    endcase
  end

  assign big_endian_o = be_q;

  // R9: mode moves only on an exact magic write
  a_r9_mode_on_magic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(be_q) |-> $past(wr_en) &&
      ($past(wdata_i) == MAGIC_BE || $past(wdata_i) == MAGIC_LE));
endmodule

// File: rtl/disp_access_seq.sv
module disp_access_seq
  import disp_mmio_pkg::*;
#(
  parameter int OFF_W     = 5,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int IDX_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  win_e              win_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       imm_rdata_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [31:0]       resp_rdata_o,
  output logic              lp_valid_o,
  output logic              lp_write_o,
  output logic [PORT_W-1:0] lp_port_o,
  output logic [7:0]        lp_wdata_o,
  input  logic [7:0]        lp_rdata_i,
  output logic              ext_idx_we_o,
  output logic [IDX_W-1:0]  ext_idx_o,
  output logic              ext_data_we_o,
  output logic              ext_data_re_o,
  output logic [15:0]       ext_wdata_o,
  input  logic [15:0]       ext_rdata_i
);
  logic             active_q, leg_q, write_q, resp_q;
  logic [1:0]       step_q, last_q;
  logic [OFF_W-1:0] off_q;
  logic [31:0]      wdata_q, acc_q;
  logic [1:0]       leg_last;

  assign leg_last = size_i[1] ? 2'd3 : (size_i[0] ? 2'd1 : 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; leg_q <= 1'b0; write_q <= 1'b0; resp_q <= 1'b0;
      step_q <= '0; last_q <= '0; off_q <= '0; wdata_q <= '0; acc_q <= '0;
    end else begin
      resp_q <= 1'b0;
      if (start_i) begin
        off_q   <= off_i;
        write_q <= write_i;
        wdata_q <= wdata_i;
        step_q  <= '0;
        acc_q   <= '0;
        unique case (win_i)
          WIN_LEG: begin active_q <= 1'b1; leg_q <= 1'b1; last_q <= leg_last; end
          WIN_EXT: begin active_q <= 1'b1; leg_q <= 1'b0; last_q <= 2'd1; end
          default: begin resp_q <= 1'b1; acc_q <= imm_rdata_i; end
        endcase
      end else if (active_q) begin
        if (!write_q) begin
          if (leg_q)              acc_q[{step_q, 3'b000} +: 8] <= lp_rdata_i;
          else if (step_q == 2'd1) acc_q[15:0] <= ext_rdata_i;
        end
        if (step_q == last_q) begin
          active_q <= 1'b0;
          resp_q   <= 1'b1;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end
    end
  end

  assign busy_o        = active_q;
  assign resp_valid_o  = resp_q;
  assign resp_rdata_o  = acc_q;
  assign lp_valid_o    = active_q && leg_q;
  assign lp_write_o    = write_q;
  assign lp_port_o     = PORT_W'(PORT_BASE) + PORT_W'(off_q) + PORT_W'(step_q);
  assign lp_wdata_o    = wdata_q[{step_q, 3'b000} +: 8];
  assign ext_idx_we_o  = active_q && !leg_q && step_q == 2'd0;
  assign ext_idx_o     = off_q[IDX_W:1];
  assign ext_data_we_o = active_q && !leg_q && step_q == 2'd1 && write_q;
  assign ext_data_re_o = active_q && !leg_q && step_q == 2'd1 && !write_q;
  assign ext_wdata_o   = wdata_q[15:0];

  a_r6_index_before_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_idx_we_o |=> (ext_data_we_o || ext_data_re_o));
  a_r5_ports_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_valid_o && $past(lp_valid_o) |-> lp_port_o == $past(lp_port_o) + PORT_W'(1));
  a_r13_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lp_valid_o, ext_idx_we_o, ext_data_we_o, ext_data_re_o}));
  a_r13_resp_follows_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(busy_o) || $past(start_i));
  a_r13_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(start_i) |-> $stable(off_q) && $stable(wdata_q));
endmodule

// File: rtl/disp_mmio_window.sv
module disp_mmio_window
  import disp_mmio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_SPAN  = 'h16,
  parameter int FEAT_BASE = 'h600,
  parameter int FEAT_SPAN = 8,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int REV_BASE  = 1,
  parameter int REV_FEAT  = 2,
  localparam int OFF_W    = $clog2(LEG_SPAN),
  localparam int IDX_W    = $clog2((EXT_SPAN + 1) / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              feat_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [31:0]       resp_rdata_o,
  output logic              lp_valid_o,
  output logic              lp_write_o,
  output logic [PORT_W-1:0] lp_port_o,
  output logic [7:0]        lp_wdata_o,
  input  logic [7:0]        lp_rdata_i,
  output logic              ext_idx_we_o,
  output logic [IDX_W-1:0]  ext_idx_o,
  output logic              ext_data_we_o,
  output logic              ext_data_re_o,
  output logic [15:0]       ext_wdata_o,
  input  logic [15:0]       ext_rdata_i,
  output logic              big_endian_o,
  output logic [7:0]        revision_o
);
  win_e             win;
  logic [OFF_W-1:0] off;
  logic             start, feat_ok;
  logic [31:0]      feat_rdata, imm_rdata;

  disp_win_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
    .EXT_BASE(EXT_BASE), .EXT_SPAN(EXT_SPAN),
    .FEAT_BASE(FEAT_BASE), .FEAT_SPAN(FEAT_SPAN)
  ) u_dec (
    .addr_i(req_addr_i), .feat_en_i(feat_en_i), .win_o(win), .off_o(off)
  );

  assign start     = req_valid_i && !busy_o;
  assign feat_ok   = win == WIN_FEAT && req_size_i == 2'd2;
  assign imm_rdata = (feat_ok && !req_write_i) ? feat_rdata : '0;

  disp_feat_regs #(.FEAT_SPAN(FEAT_SPAN)) u_feat (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(start && feat_ok),
    .write_i(req_write_i), .off_i(off[2:0]), .wdata_i(req_wdata_i),
    .big_endian_o(big_endian_o), .rdata_o(feat_rdata)
  );

  disp_access_seq #(
    .OFF_W(OFF_W), .PORT_W(PORT_W), .PORT_BASE(PORT_BASE), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .win_i(win), .off_i(off),
    .write_i(req_write_i), .size_i(req_size_i), .wdata_i(req_wdata_i),
    .imm_rdata_i(imm_rdata), .busy_o(busy_o), .resp_valid_o(resp_valid_o),
    .resp_rdata_o(resp_rdata_o), .lp_valid_o(lp_valid_o), .lp_write_o(lp_write_o),
    .lp_port_o(lp_port_o), .lp_wdata_o(lp_wdata_o), .lp_rdata_i(lp_rdata_i),
    .ext_idx_we_o(ext_idx_we_o), .ext_idx_o(ext_idx_o),
    .ext_data_we_o(ext_data_we_o), .ext_data_re_o(ext_data_re_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i)
  );

  assign revision_o = feat_en_i ? 8'(REV_FEAT) : 8'(REV_BASE);

  // R12: unmapped request never reaches a backend
  a_r12_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && win == WIN_NONE |=> !lp_valid_o && !ext_idx_we_o && resp_valid_o);
  // R10: narrow feature access cannot move the mode
  a_r10_narrow_feat_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && win == WIN_FEAT && req_size_i != 2'd2 |=> $stable(big_endian_o));
endmodule

// File: tb/sim_disp_mmio_window.sv
module sim_disp_mmio_window;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, feat_en = 1;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic busy, resp_valid, lp_valid, lp_write, ext_idx_we, ext_data_we, ext_data_re, big_endian;
  logic [31:0] resp_rdata;
  logic [9:0]  lp_port;
  logic [7:0]  lp_wdata, lp_rdata, revision;
  logic [3:0]  ext_idx;
  logic [15:0] ext_wdata, ext_rdata;

  always #(CLK_P/2) clk = ~clk;

  disp_mmio_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .feat_en_i(feat_en), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .busy_o(busy), .resp_valid_o(resp_valid),
    .resp_rdata_o(resp_rdata), .lp_valid_o(lp_valid), .lp_write_o(lp_write),
    .lp_port_o(lp_port), .lp_wdata_o(lp_wdata), .lp_rdata_i(lp_rdata),
    .ext_idx_we_o(ext_idx_we), .ext_idx_o(ext_idx), .ext_data_we_o(ext_data_we),
    .ext_data_re_o(ext_data_re), .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata),
    .big_endian_o(big_endian), .revision_o(revision)
  );

  // stub backends
  assign lp_rdata = lp_port[7:0] ^ 8'hA5;
  logic [15:0] ext_mem [16];
  logic [3:0]  ext_ptr;
  assign ext_rdata = ext_mem[ext_ptr];
  always @(posedge clk) begin
    if (!rst_n) begin
      ext_ptr <= '0;
      for (int i = 0; i < 16; i++) ext_mem[i] <= 16'hC000 + 16'(i * 16'h0111);
    end else begin
      if (ext_idx_we)  ext_ptr <= ext_idx;
      if (ext_data_we) ext_mem[ext_ptr] <= ext_wdata;
    end
  end

  // strobe logs
  logic [9:0]  lp_port_l [64];
  logic        lp_we_l   [64];
  logic [7:0]  lp_dat_l  [64];
  logic [1:0]  ex_kind_l [64];
  logic [15:0] ex_val_l  [64];
  int lp_tot = 0, ex_tot = 0;
  always @(negedge clk) begin
    if (rst_n && lp_valid) begin
      lp_port_l[lp_tot % 64] <= lp_port;
      lp_we_l[lp_tot % 64]   <= lp_write;
      lp_dat_l[lp_tot % 64]  <= lp_wdata;
      lp_tot <= lp_tot + 1;
    end
    if (rst_n && (ext_idx_we || ext_data_we || ext_data_re)) begin
      ex_kind_l[ex_tot % 64] <= ext_idx_we ? 2'd0 : (ext_data_we ? 2'd1 : 2'd2);
      ex_val_l[ex_tot % 64]  <= ext_idx_we ? 16'(ext_idx) : ext_wdata;
      ex_tot <= ex_tot + 1;
    end
  end

  int total = 0, bad = 0;
  int lp0, ex0, lat;
  logic [31:0] rd;
  logic timed_out = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    lp0 = lp_tot; ex0 = ex_tot;
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (resp_valid) break;
    end
    rd = resp_rdata;
    #1;
  endtask

  function automatic logic [7:0] lbyte(input int off);
    return 8'((10'h3C0 + 10'(off)) & 10'h0FF) ^ 8'hA5;
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 resp_valid", 32'(resp_valid), 0);
        chk("R1 strobes", 32'({lp_valid, ext_idx_we, ext_data_we, ext_data_re}), 0);
        chk("R1 big_endian", 32'(big_endian), 0);
        chk("R11 revision en", 32'(revision), 2);

        // R2 byte reads and writes across the legacy window
        for (int n = 0; n < 32; n++) begin
          access(0, 12'(12'h400 + n), 2'd0, 0);
          chk("R2 rd data", rd, {24'h0, lbyte(n)});
          chk("R2 strobes", lp_tot - lp0, 1);
          chk("R2 port", 32'(lp_port_l[lp0 % 64]), 32'h3C0 + n);
          chk("R13 latency byte", lat, 2);
          access(1, 12'(12'h400 + n), 2'd0, 32'(8'h30 + n));
          chk("R2 wr port", 32'(lp_port_l[lp0 % 64]), 32'h3C0 + n);
          chk("R2 wr data", {lp_we_l[lp0 % 64], lp_dat_l[lp0 % 64]}, {1'b1, 8'(8'h30 + n)});
        end

        // R3 / R4 half accesses
        for (int n = 0; n < 31; n++) begin
          access(1, 12'(12'h400 + n), 2'd1, 32'(16'h1200 + n * 3));
          chk("R3 strobes", lp_tot - lp0, 2);
          chk("R3 first port", 32'(lp_port_l[lp0 % 64]), 32'h3C0 + n);
          chk("R3 first byte", 32'(lp_dat_l[lp0 % 64]), 32'((16'h1200 + n * 3) & 16'hFF));
          chk("R3 second port", 32'(lp_port_l[(lp0 + 1) % 64]), 32'h3C1 + n);
          chk("R3 second byte", 32'(lp_dat_l[(lp0 + 1) % 64]), 32'(16'(16'h1200 + n * 3) >> 8));
          access(0, 12'(12'h400 + n), 2'd1, 0);
          chk("R4 rd data", rd, {16'h0, lbyte(n + 1), lbyte(n)});
          chk("R13 latency half", lat, 3);
        end

        // R5 word accesses
        for (int n = 0; n < 29; n += 4) begin
          access(0, 12'(12'h400 + n), 2'd2, 0);
          chk("R5 rd data", rd, {lbyte(n + 3), lbyte(n + 2), lbyte(n + 1), lbyte(n)});
          chk("R13 latency word", lat, 5);
          access(1, 12'(12'h400 + n), 2'd3, 32'hDDCC_BBAA);
          chk("R5 strobes", lp_tot - lp0, 4);
          for (int k = 0; k < 4; k++) begin
            chk("R5 port", 32'(lp_port_l[(lp0 + k) % 64]), 32'h3C0 + n + k);
            chk("R5 byte", 32'(lp_dat_l[(lp0 + k) % 64]), 32'(8'hAA + 8'(k * 8'h11)));
          end
        end

        // R6 indexed extension registers
        for (int i = 0; i < 11; i++) begin
          access(0, 12'(12'h500 + 2 * i + 1), 2'd1, 0);
          chk("R6 initial rd", rd, 32'(16'hC000 + 16'(i * 16'h0111)));
          chk("R13 latency ext", lat, 3);
          access(1, 12'(12'h500 + 2 * i), 2'd2, 32'(32'hFFFF_0000 + 32'h7700 + i));
          chk("R6 idx first", {30'h0, ex_kind_l[ex0 % 64]}, 0);
          chk("R6 idx value", 32'(ex_val_l[ex0 % 64]), i);
          chk("R6 data second", {30'h0, ex_kind_l[(ex0 + 1) % 64]}, 1);
          chk("R6 data value", 32'(ex_val_l[(ex0 + 1) % 64]), 32'h7700 + i);
          access(0, 12'(12'h500 + 2 * i), 2'd0, 0);
          chk("R6 readback", rd, 32'h7700 + i);
        end

        // R7 / R8 / R9 feature registers
        access(0, 12'h600, 2'd2, 0);  chk("R7 size reg", rd, 8);
        chk("R13 latency feat", lat, 1);
        access(0, 12'h604, 2'd2, 0);  chk("R8 le read", rd, 32'h1E1E_1E1E);
        access(1, 12'h604, 2'd2, 32'hBEBE_BEBE);
        chk("R9 set", 32'(big_endian), 1);
        access(0, 12'h604, 2'd2, 0);  chk("R8 be read", rd, 32'hBEBE_BEBE);
        access(1, 12'h604, 2'd2, 32'h1E1E_1E1F);
        chk("R9 near miss", 32'(big_endian), 1);
        access(1, 12'h604, 2'd2, 32'h0000_0000);
        chk("R9 zero", 32'(big_endian), 1);
        access(1, 12'h600, 2'd2, 32'h1E1E_1E1E);
        chk("R9 wrong offset", 32'(big_endian), 1);
        access(1, 12'h604, 2'd2, 32'h1E1E_1E1E);
        chk("R9 clear", 32'(big_endian), 0);
        access(1, 12'h604, 2'd2, 32'hBEBE_BEBF);
        chk("R9 near miss set", 32'(big_endian), 0);

        // R10 narrow feature accesses and undefined offset
        access(1, 12'h604, 2'd1, 32'hBEBE_BEBE);
        chk("R10 half write", 32'(big_endian), 0);
        access(1, 12'h604, 2'd3, 32'hBEBE_BEBE);
        chk("R10 size3 write", 32'(big_endian), 0);
        access(0, 12'h600, 2'd1, 0);  chk("R10 half read", rd, 0);
        access(0, 12'h602, 2'd2, 0);  chk("R10 undefined", rd, 0);

        // R12 unmapped
        begin
          logic [11:0] um [8] = '{12'h000, 12'h3FF, 12'h420, 12'h4FF,
                                  12'h516, 12'h5FF, 12'h608, 12'hFFF};
          for (int j = 0; j < 8; j++) begin
            access(0, um[j], 2'd2, 0);
            chk("R12 rd zero", rd, 0);
            chk("R12 latency", lat, 1);
            chk("R12 no strobe", (lp_tot - lp0) + (ex_tot - ex0), 0);
          end
        end

        // R11 feature window disabled
        feat_en = 0;
        #1 chk("R11 revision dis", 32'(revision), 1);
        access(0, 12'h600, 2'd2, 0);  chk("R11 size hidden", rd, 0);
        access(1, 12'h604, 2'd2, 32'hBEBE_BEBE);
        chk("R11 write ignored", 32'(big_endian), 0);
        feat_en = 1;

        // R13 request during busy is dropped
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h400; req_size = 2'd2;
        req_wdata = 32'h0403_0201; lp0 = lp_tot;
        @(posedge clk);
        #1 req_addr = 12'h604; req_wdata = 32'hBEBE_BEBE;
        @(posedge clk);
        #1 req_valid = 0;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          if (resp_valid) break;
        end
        #1;
        chk("R13 busy drop mode", 32'(big_endian), 0);
        chk("R13 busy strobes", lp_tot - lp0, 4);
      end
      begin
        #(CLK_P * 200000);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule